// File: doc/BRIEF.md
# Virtual Compare Timer

This block is a comparator-style event timer that watches a 64-bit virtual count held inside the block. The count advances by one on every clock cycle in which the increment strobe is high. Software programs a 64-bit compare value. When the timer is enabled and the count has reached or passed the compare value, the block raises a status bit and, unless the interrupt is masked, a level interrupt. Reaching or passing is judged by the sign of the 64-bit difference.

Besides the absolute compare value, the block offers a signed 32-bit "remaining time" view. Writing it arms the timer relative to the present count. Reading it gives the distance still to go, which shrinks as the count advances, so software can treat the timer as a down-counter. There is no reload or decrement logic behind it. A small register port with a shared address, a write strobe and a combinational read path gives access to the compare value, the remaining-time view and the control word.

Top module: `vcmp_timer`

## Requirements
- R1: After reset the count, the compare value, enable and mask are all zero, the status bit is zero and `irq_o` is low. Reads at every address return zero until the first write.
- R2: The internal count increases by exactly one on each rising clock edge where `tick_i` is 1, and holds its value otherwise.
- R3: A write to address 1 (remaining-time view) loads the compare value with the present count plus `reg_wdata_i[31:0]`, sign-extended to 64 bits. Bits 63:32 of the written word have no effect.
- R4: With enable set, a read of address 1 returns (compare minus count) truncated to 32 bits, in bits 31:0, with bits 63:32 zero.
- R5: With enable clear, a read of address 1 returns zero.
- R6: A write to address 0 loads all 64 bits of the compare value, and a read of address 0 returns it.
- R7: Address 2 is the control word: bit 0 enable, bit 1 interrupt mask, bit 2 status. Bits 0 and 1 are writable. Bit 2 is read-only, so writes to it are ignored. All other bits and all of address 3 read as zero.
- R8: The status bit becomes 1 on the clock edge after enable is 1 and the signed 64-bit value (count minus compare) is zero or positive, and becomes 0 on the edge after that stops holding.
- R9: `irq_o` is high exactly when the status bit is 1 and the mask bit is 0.
- R10: With enable clear, the status bit and `irq_o` go low one edge later, and the count keeps advancing. After re-enabling, the remaining-time view reflects every tick that arrived while the timer was disabled.
- R11: The condition uses the signed difference across the full 64-bit wrap. A compare value exactly 2^63 ahead of the count does not meet the condition. A compare value 2^63+1 ahead of the count does meet it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count increment strobe |
| reg_addr_i | input | 2 | Register address: 0 compare, 1 remaining-time view, 2 control, 3 unused |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench drives the remaining-time view with negative values and with junk in the upper half of the word. A design that forgets the sign extension, or that lets bits 63:32 through, arms the timer billions of ticks away or in the wrong direction.

It places the compare value exactly 2^63 and 2^63+1 ahead of the count. An unsigned or 63-bit comparison gives the wrong answer at one of those two points.

It checks the one-edge lag of status when the condition starts and when it ends. It also writes the status bit directly, and it ticks the count while the timer is disabled. A design with a combinational status path, a writable status bit, or a count that stalls while disabled shows a mismatch against the reference model on the very next cycle.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

   // Register addresses on the simple access port
   typedef enum logic [1:0] {
      VT_ADDR_CMP  = 2'd0,
      VT_ADDR_TVAL = 2'd1,
      VT_ADDR_CTRL = 2'd2,
      VT_ADDR_NONE = 2'd3
   } vt_addr_e;

   // Control word bit positions (software decodes these)
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_MASK_BIT = 1;
   localparam int unsigned CTRL_STAT_BIT = 2;
   localparam int unsigned CTRL_W        = 3;

   typedef struct packed {
      logic mask;
      logic en;
   } vt_ctrl_t;

endpackage

// File: rtl/vcmp_counter.sv
module vcmp_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("vcmp_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (tick_i) begin
         count_q <= count_q + ONE;
      end
   end

   assign count_o = count_q;

   // R2: one step per strobe
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (count_q == $past(count_q) + ONE));

   // R2: no strobe, no change
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(count_q));

endmodule

// File: rtl/vcmp_condition.sv
module vcmp_condition #(
   parameter int unsigned CNT_W        = 64,
   parameter bit          STATUS_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             status_o
);

   logic [CNT_W-1:0] diff;
   logic             met;

   // Signed difference count - cmp; sign bit clear means reached or passed
   assign diff = count_i - cmp_i;
   assign met  = en_i & ~diff[CNT_W-1];

   generate
      if (STATUS_STAGE) begin : g_reg_status
         logic status_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status_q <= 1'b0;
            end else begin
               status_q <= met;
            end
         end

         assign status_o = status_q;

         // R10: disabled timer drops status on the next edge
         assert_dis_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |=> !status_o);

         // R8: compare reached exactly sets status next edge
         assert_equal_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && (count_i == cmp_i)) |=> status_o);

         // R11: compare one ahead of the count never sets status
         assert_ahead_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_i == count_i + CNT_W'(1)) |=> !status_o);
      end else begin : g_comb_status
         assign status_o = met;
      end
   endgenerate

endmodule

// File: rtl/vcmp_regs.sv
module vcmp_regs
   import vcmp_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned TV_W   = 32,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              status_i,
   output logic [CNT_W-1:0]  cmp_o,
   output vt_ctrl_t          ctrl_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned EXT_W = CNT_W - TV_W;

   generate
      if (TV_W >= CNT_W) begin : g_bad_tv
         $error("vcmp_regs: TV_W must be narrower than CNT_W");
      end
      if (DATA_W < CNT_W) begin : g_bad_data
         $error("vcmp_regs: DATA_W must hold a full compare value");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q;
   vt_ctrl_t         ctrl_q;
   logic [CNT_W-1:0] tv_sext;
   logic [CNT_W-1:0] tv_view;
   logic [TV_W-1:0]  tv_rd;
   logic [CTRL_W-1:0] ctrl_rd;
   vt_addr_e         addr;

   assign addr    = vt_addr_e'(addr_i);
   assign tv_sext = {{EXT_W{wdata_i[TV_W-1]}}, wdata_i[TV_W-1:0]};
   assign tv_view = cmp_q - count_i;
   assign tv_rd   = ctrl_q.en ? tv_view[TV_W-1:0] : '0;

   always_comb begin
      ctrl_rd                = '0;
      ctrl_rd[CTRL_EN_BIT]   = ctrl_q.en;
      ctrl_rd[CTRL_MASK_BIT] = ctrl_q.mask;
      ctrl_rd[CTRL_STAT_BIT] = status_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         ctrl_q <= '0;
      end else if (wr_i) begin
         unique case (addr)
            VT_ADDR_CMP:  cmp_q <= wdata_i[CNT_W-1:0];
            VT_ADDR_TVAL: cmp_q <= count_i + tv_sext;
            VT_ADDR_CTRL: begin
               ctrl_q.en   <= wdata_i[CTRL_EN_BIT];
               ctrl_q.mask <= wdata_i[CTRL_MASK_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (addr)
         VT_ADDR_CMP:  rdata_o = DATA_W'(cmp_q);
         VT_ADDR_TVAL: rdata_o = DATA_W'(tv_rd);
         VT_ADDR_CTRL: rdata_o = DATA_W'(ctrl_rd);
         default:      rdata_o = '0;
      endcase
   end

   assign cmp_o  = cmp_q;
   assign ctrl_o = ctrl_q;

   // R3: relative arming from the count seen at the write edge
   assert_tval_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr == VT_ADDR_TVAL) |=>
         (cmp_q == $past(count_i) + $past(tv_sext)));

   // R6: writes elsewhere leave the compare value alone
   assert_cmp_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i || addr == VT_ADDR_CTRL || addr == VT_ADDR_NONE) |=> $stable(cmp_q));

   // R5: disabled view reads as zero
   assert_tval_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == VT_ADDR_TVAL && !ctrl_q.en) |-> (rdata_o == '0));

endmodule

// File: rtl/vcmp_timer.sv
module vcmp_timer
   import vcmp_pkg::*;
#(
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned TV_W         = 32,
   parameter int unsigned DATA_W       = 64,
   parameter bit          STATUS_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] cmp;
   vt_ctrl_t         ctrl;
   logic             status;

   vcmp_counter #(.CNT_W(CNT_W)) counter_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .count_o (count)
   );

   vcmp_regs #(.CNT_W(CNT_W), .TV_W(TV_W), .DATA_W(DATA_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (reg_addr_i),
      .wr_i     (reg_wr_i),
      .wdata_i  (reg_wdata_i),
      .count_i  (count),
      .status_i (status),
      .cmp_o    (cmp),
      .ctrl_o   (ctrl),
      .rdata_o  (reg_rdata_o)
   );

   vcmp_condition #(.CNT_W(CNT_W), .STATUS_STAGE(STATUS_STAGE)) cond_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ctrl.en),
      .count_i  (count),
      .cmp_i    (cmp),
      .status_o (status)
   );

   assign irq_o = status & ~ctrl.mask;

   // R9: masked timer never interrupts
   assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.mask |-> !irq_o);

   // R9: interrupt implies status
   assert_irq_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> status);

endmodule

// File: tb/vcmp_timer_tb.sv
`timescale 1ns/1ps
module vcmp_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [1:0]  reg_addr_i = 2'd0;
   logic        reg_wr_i = 1'b0;
   logic [63:0] reg_wdata_i = '0;
   logic [63:0] reg_rdata_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   longint unsigned m_count, m_cmp;
   bit m_en, m_mask, m_status;

   always #2 clk = ~clk;

   vcmp_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic longint unsigned model_read(input logic [1:0] a);
      longint unsigned d;
      case (a)
         2'd0: return m_cmp;
         2'd1: begin
            d = m_cmp - m_count;
            return m_en ? {32'd0, d[31:0]} : 64'd0;
         end
         2'd2: return {61'd0, m_status, m_mask, m_en};
         default: return 64'd0;
      endcase
   endfunction

   function automatic string read_tag(input logic [1:0] a);
      case (a)
         2'd0: return "R6";
         2'd1: return m_en ? "R4" : "R5";
         2'd2: return "R7";
         default: return "R7";
      endcase
   endfunction

   // One clock: drive, compare against model, advance model
   task automatic cyc(input bit tk, input bit wr, input logic [1:0] a,
                      input logic [63:0] wd, output logic [63:0] rd, output bit iq);
      longint signed diff;
      longint unsigned n_count, n_cmp;
      bit n_en, n_mask, n_status;
      @(negedge clk);
      tick_i = tk; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
      #1;
      rd = reg_rdata_o;
      iq = irq_o;
      check(read_tag(a), rd, model_read(a));
      check("R9", {63'd0, iq}, {63'd0, m_status & ~m_mask});
      // next state per requirements R2, R3, R6, R7, R8
      diff = longint'(m_count - m_cmp);
      n_status = m_en && (diff >= 0);
      n_count = m_count; n_cmp = m_cmp; n_en = m_en; n_mask = m_mask;
      if (wr) begin
         case (a)
            2'd0: n_cmp = wd;
            2'd1: n_cmp = m_count + longint'(int'(wd[31:0]));
            2'd2: begin n_en = wd[0]; n_mask = wd[1]; end
            default: ;
         endcase
      end
      if (tk) n_count = m_count + 64'd1;
      @(posedge clk);
      m_count = n_count; m_cmp = n_cmp; m_en = n_en; m_mask = n_mask; m_status = n_status;
   endtask

   task automatic idle(input int n);
      logic [63:0] rd; bit iq;
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd3, 64'd0, rd, iq);
   endtask

   task automatic ticks(input int n);
      logic [63:0] rd; bit iq;
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd1, 64'd0, rd, iq);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] rd;
      bit iq;
      m_count = 0; m_cmp = 0; m_en = 0; m_mask = 0; m_status = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      cyc(0, 0, 2'd2, 0, rd, iq); check("R1", rd, 64'd0); check("R1", {63'd0, iq}, 64'd0);
      cyc(0, 0, 2'd0, 0, rd, iq); check("R1", rd, 64'd0);
      cyc(0, 0, 2'd1, 0, rd, iq); check("R1", rd, 64'd0);

      // R2: count to 5, then enable
      ticks(5);
      cyc(0, 1, 2'd2, 64'd1, rd, iq);
      // R3: upper half ignored, arm 16 ahead -> compare 21
      cyc(0, 1, 2'd1, 64'hABCD_0000_0000_0010, rd, iq);
      cyc(0, 0, 2'd0, 0, rd, iq); check("R3", rd, 64'd21);
      cyc(0, 0, 2'd1, 0, rd, iq); check("R4", rd, 64'd16);
      ticks(16);
      // R8: status lags one edge behind count reaching compare
      cyc(0, 0, 2'd2, 0, rd, iq); check("R8", {63'd0, iq}, 64'd0);
      cyc(0, 0, 2'd2, 0, rd, iq); check("R8", {63'd0, iq}, 64'd1); check("R7", rd, 64'd5);
      // R7/R9: mask with status bit written as 0
      cyc(0, 1, 2'd2, 64'd3, rd, iq);
      cyc(0, 0, 2'd2, 0, rd, iq); check("R9", {63'd0, iq}, 64'd0); check("R7", rd, 64'd7);
      // R7/R10: write only status bit, disabling the timer
      cyc(0, 1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFC, rd, iq);
      idle(1);
      cyc(0, 0, 2'd2, 0, rd, iq); check("R10", rd, 64'd0);
      ticks(10);
      cyc(0, 0, 2'd1, 0, rd, iq); check("R5", rd, 64'd0);
      // R10: re-enable, view shows 21 - 31 = -10
      cyc(0, 1, 2'd2, 64'd1, rd, iq);
      cyc(0, 0, 2'd1, 0, rd, iq); check("R10", rd, 64'h0000_0000_FFFF_FFF6);
      // R3: negative relative write
      cyc(0, 1, 2'd1, 64'h0000_0000_FFFF_FFFB, rd, iq);
      cyc(0, 0, 2'd0, 0, rd, iq); check("R3", rd, 64'd26);
      // R11: compare exactly 2^63 ahead of count 31
      cyc(0, 1, 2'd0, 64'h8000_0000_0000_001F, rd, iq);
      idle(2);
      cyc(0, 0, 2'd2, 0, rd, iq); check("R11", rd, 64'd1);
      // R11: 2^63 + 1 ahead meets the condition
      cyc(0, 1, 2'd0, 64'h8000_0000_0000_0020, rd, iq);
      idle(1);
      cyc(0, 0, 2'd2, 0, rd, iq); check("R11", rd, 64'd5); check("R11", {63'd0, iq}, 64'd1);

      // mixed random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int sel = $urandom_range(0, 9);
         bit tk = $urandom_range(0, 1);
         logic [1:0] a = 2'($urandom_range(0, 3));
         logic [63:0] wd;
         bit wr = 1'b0;
         wd = {$urandom, $urandom};
         if (sel == 0) begin
            wr = 1; a = 2'd2; wd[1:0] = 2'($urandom_range(0, 3));
         end else if (sel == 1) begin
            wr = 1; a = 2'd1;
            wd[31:0] = 32'($signed($urandom_range(0, 60)) - 20);
         end else if (sel == 2) begin
            wr = 1; a = 2'd0;
            if ($urandom_range(0, 1)) wd = m_count + 64'($urandom_range(0, 12)) - 64'd6;
         end else if (sel == 3) begin
            wr = 1; a = 2'd3;
         end
         cyc(tk, wr, a, wd, rd, iq);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule